// File: doc/BRIEF.md
# Clock Rate Meter

The block measures how fast an unknown clock runs by counting its rising edges while a timer, clocked by a trusted reference, stays open for a programmed number of reference periods. Software writes a tick count together with a start flag. The block opens the window, closes it after that many reference periods, and raises a done flag. The edge count then appears in the status word. A select input picks which of several candidate clocks is counted.

Three clock domains meet here: the register clock, the reference clock and the selected test clock. The start request crosses into the reference domain through a two-flop synchroniser. The counting window crosses into the test domain the same way. The edge count returns as a Gray-coded word through two-flop synchronisers. The done flag is held back for a settling interval so that the captured count is stable before done rises.

The edge counter is only cleared when a new window opens in its own clock domain. A stopped clock therefore never clears it, and every later run reports the old value. Software finds a dead clock by comparing a short run with a long run: equal counts mean no edges. Software turns the count into a rate as count × f_ref / ticks, plus small offsets that it applies itself.

Top module: `clk_rate_meter`

## Requirements
- R1: After reset the status word reads zero.
- R2: Control word layout: bits 19:0 hold the reference tick count and bit 20 is the start flag. Bits 31:21 are ignored. Status word layout: bit 25 is done, bits 24:0 hold the count zero-extended from CNT_W bits, and bits 31:26 read zero.
- R3: Once started, the window stays open for exactly the programmed number of reference periods. The reported count equals the number of rising edges of the selected clock during the window, within ±2.
- R4: test_sel_i picks which test_clk_i bit is counted. Different sources at different rates give proportionally different counts.
- R5: Writing a control word with the start flag clear closes the window and clears done within a few register cycles. Done stays low while start is clear.
- R6: The edge counter never clears unless the selected clock toggles. With a stopped clock, a short run and a long run both report the count left by the last run that had a running clock.
- R7: The count saturates at 2^CNT_W-1 and does not wrap.
- R8: While done stays high, the count field does not change.
- R9: A new run on a running clock restarts the count from zero. It does not accumulate the result of the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous active-low reset, all domains |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word (ticks, start flag) |
| status_o | output | 32 | Status word (done, count) |
| ref_clk_i | input | 1 | Reference clock for the window timer |
| test_clk_i | input | N_SRC | Candidate clocks to be measured |
| test_sel_i | input | SEL_W | Index of the clock to measure |

## Verification
After a start write, done is due about ticks reference periods later. On top of that come two reference cycles for the start synchroniser, two register cycles for the done synchroniser and SETTLE_CYC register cycles of settling. The bench therefore polls done with a bound derived from the tick count, rather than expecting it on a fixed cycle. After a stop write, done must be low within about ten register cycles. A behavioural model tracks how many cycles have passed since start was last cleared, and from 40 cycles on it checks on every register clock that done is low and that the reserved bits read zero. Counts are compared against ticks × reference period / test period, with a ±2 tolerance for the synchroniser phase. Stopped-clock runs and saturation are compared exactly.

// File: rtl/crm_pkg.sv
package crm_pkg;
  localparam int unsigned TICK_W        = 20;
  localparam int unsigned START_BIT     = 20;
  localparam int unsigned STAT_CNT_W    = 25;
  localparam int unsigned STAT_DONE_BIT = 25;
  localparam int unsigned WORD_W        = 32;
endpackage

// File: rtl/crm_sync2.sv
module crm_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/crm_ref_window.sv
module crm_ref_window #(
  parameter int unsigned TICK_W = 20
) (
  input  logic              ref_clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [TICK_W-1:0] ticks_i,
  output logic              gate_o,
  output logic              done_o
);
  logic              run_s, run_d;
  logic              gate_q, done_q;
  logic [TICK_W-1:0] timer_q;

  crm_sync2 #(.W(1)) u_run_sync (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .d_i   (run_i),
    .q_o   (run_s)
  );

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_d   <= 1'b0;
      gate_q  <= 1'b0;
      done_q  <= 1'b0;
      timer_q <= '0;
    end else begin
      run_d <= run_s;
      if (!run_s) begin
        gate_q  <= 1'b0;
        done_q  <= 1'b0;
        timer_q <= '0;
      end else if (!run_d) begin
        // ticks_i is quasi-static: written before run reaches this domain
        if (ticks_i == '0) begin
          done_q <= 1'b1;
        end else begin
          gate_q  <= 1'b1;
          timer_q <= ticks_i;
        end
      end else if (gate_q) begin
        timer_q <= timer_q - 1'b1;
        if (timer_q == TICK_W'(1)) begin
          gate_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign gate_o = gate_q;
  assign done_o = done_q;

  assert_stop_clears_R5: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !run_s |=> (!gate_q && !done_q));

  assert_done_after_window_R3: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    done_q |-> !gate_q);

  assert_window_closes_at_zero_R3: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $fell(gate_q) && run_s |-> done_q);
endmodule

// File: rtl/crm_edge_counter.sv
module crm_edge_counter #(
  parameter int unsigned CNT_W = 25
) (
  input  logic             meas_clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  output logic [CNT_W-1:0] gray_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             gate_s, gate_d;
  logic [CNT_W-1:0] cnt_q, cnt_nx, gray_q;

  crm_sync2 #(.W(1)) u_gate_sync (
    .clk_i (meas_clk_i),
    .rst_ni(rst_ni),
    .d_i   (gate_i),
    .q_o   (gate_s)
  );

  // cleared only on a window opening seen in this domain: a dead clock keeps the old value
  always_comb begin
    cnt_nx = cnt_q;
    if (gate_s && !gate_d)       cnt_nx = CNT_W'(1);
    else if (gate_s && cnt_q != CNT_MAX) cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge meas_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_d <= 1'b0;
      cnt_q  <= '0;
      gray_q <= '0;
    end else begin
      gate_d <= gate_s;
      cnt_q  <= cnt_nx;
      gray_q <= cnt_nx ^ (cnt_nx >> 1);
    end
  end

  assign gray_o = gray_q;

  assert_sat_hold_R7: assert property (@(posedge meas_clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && gate_s && gate_d) |=> cnt_q == CNT_MAX);

  assert_idle_hold_R6: assert property (@(posedge meas_clk_i) disable iff (!rst_ni)
    !gate_s |=> $stable(cnt_q));

  assert_gray_step_R9: assert property (@(posedge meas_clk_i) disable iff (!rst_ni)
    (gate_s && gate_d) |=> $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/clk_rate_meter.sv
module clk_rate_meter
  import crm_pkg::*;
#(
  parameter int unsigned N_SRC      = 4,
  parameter int unsigned CNT_W      = 25,
  parameter int unsigned SETTLE_CYC = 16,
  localparam int unsigned SEL_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [WORD_W-1:0] ctrl_wdata_i,
  output logic [WORD_W-1:0] status_o,
  input  logic              ref_clk_i,
  input  logic [N_SRC-1:0]  test_clk_i,
  input  logic [SEL_W-1:0]  test_sel_i
);
  localparam int unsigned SET_W = $clog2(SETTLE_CYC + 1);

  logic [TICK_W-1:0] ticks_q;
  logic              run_q;
  logic              gate, ref_done, done_s;
  logic              meas_clk;
  logic [CNT_W-1:0]  gray, gray_s, live_bin, cap_q;
  logic [SET_W-1:0]  settle_q;
  logic              done_q;
  logic [STAT_CNT_W-1:0] cnt_field;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ticks_q <= '0;
      run_q   <= 1'b0;
    end else if (ctrl_wr_i) begin
      ticks_q <= ctrl_wdata_i[TICK_W-1:0];
      run_q   <= ctrl_wdata_i[START_BIT];
    end
  end

  crm_ref_window #(.TICK_W(TICK_W)) u_window (
    .ref_clk_i(ref_clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_q),
    .ticks_i  (ticks_q),
    .gate_o   (gate),
    .done_o   (ref_done)
  );

  always_comb begin
    meas_clk = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (test_sel_i == SEL_W'(i)) meas_clk = test_clk_i[i];
    end
  end

  crm_edge_counter #(.CNT_W(CNT_W)) u_counter (
    .meas_clk_i(meas_clk),
    .rst_ni    (rst_ni),
    .gate_i    (gate),
    .gray_o    (gray)
  );

  crm_sync2 #(.W(1)) u_done_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ref_done),
    .q_o   (done_s)
  );

  crm_sync2 #(.W(CNT_W)) u_cnt_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gray),
    .q_o   (gray_s)
  );

  always_comb begin
    live_bin[CNT_W-1] = gray_s[CNT_W-1];
    for (int i = int'(CNT_W) - 2; i >= 0; i--) begin
      live_bin[i] = live_bin[i+1] ^ gray_s[i];
    end
  end

  // done waits SETTLE_CYC after the reference side closes, so the count has landed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      settle_q <= '0;
      done_q   <= 1'b0;
      cap_q    <= '0;
    end else if (!done_s) begin
      settle_q <= '0;
      done_q   <= 1'b0;
    end else if (!done_q) begin
      if (settle_q == SET_W'(SETTLE_CYC)) begin
        done_q <= 1'b1;
        cap_q  <= live_bin;
      end else begin
        settle_q <= settle_q + 1'b1;
      end
    end
  end

  always_comb begin
    cnt_field = '0;
    cnt_field[CNT_W-1:0] = cap_q;
  end

  assign status_o = {{(WORD_W-STAT_DONE_BIT-1){1'b0}}, done_q, cnt_field};

  assert_cap_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && $past(done_q)) |-> $stable(cap_q));

  assert_done_needs_ref_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> done_s);

  assert_stop_drops_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_s |=> !done_q);
endmodule

// File: tb/clk_rate_meter_test.sv
module clk_rate_meter_test;
  localparam int CNT_W = 10;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic        clk = 0, rst_n = 0, ref_clk = 0;
  logic        ctrl_wr = 0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] status;
  logic [3:0]  tclk;
  logic [1:0]  sel = '0;
  logic        c0 = 0, c1 = 0, c2 = 0, run2 = 1;

  int checks = 0, errors = 0;
  int cycles = 0, idle_ctr = 0;
  bit start_shadow = 0;
  bit finished = 0;

  always #10 clk = ~clk;        // 50 MHz register clock
  always #20 ref_clk = ~ref_clk; // 40 ns reference period
  always #5  c0 = ~c0;           // 10 ns
  always #30 c1 = ~c1;           // 60 ns
  always #5  if (run2) c2 = ~c2; // 10 ns, stoppable
  assign tclk = {1'b0, c2, c1, c0};

  clk_rate_meter #(.N_SRC(4), .CNT_W(CNT_W), .SETTLE_CYC(16)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ctrl_wr_i   (ctrl_wr),
    .ctrl_wdata_i(ctrl_wdata),
    .status_o    (status),
    .ref_clk_i   (ref_clk),
    .test_clk_i  (tclk),
    .test_sel_i  (sel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural model: cycles elapsed with start clear
  always @(posedge clk) begin
    cycles++;
    if (start_shadow || !rst_n) idle_ctr = 0;
    else idle_ctr++;
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(status[31:26] == 6'd0, "R2 reserved bits", int'(status[31:26]), 0);
      if (idle_ctr > 40) chk(status[25] == 1'b0, "R5 done low while stopped", int'(status[25]), 0);
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    ctrl_wr = 1; ctrl_wdata = d;
    start_shadow = d[20];
    @(negedge clk);
    ctrl_wr = 0;
  endtask

  task automatic measure(input logic [1:0] s, input int ticks, input logic [31:0] junk,
                         output int cnt);
    int n;
    sel = s;
    wr(32'(ticks));
    n = 0;
    while (status[25] && n < 200) begin @(negedge clk); n++; end
    wr(junk | 32'h0010_0000 | 32'(ticks));
    n = 0;
    while (!status[25] && n < ticks * 2 + 400) begin @(negedge clk); n++; end
    chk(status[25] == 1'b1, "R3 done raised", int'(status[25]), 1);
    cnt = int'(status[24:0]);
  endtask

  function automatic bit near(input int a, input int e);
    return (a >= e - 2) && (a <= e + 2);
  endfunction

  initial begin
    int cnt, prev, cs, cl;
    repeat (5) @(negedge clk);
    chk(status == 32'd0, "R1 reset status", int'(status), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(status == 32'd0, "R1 status after reset release", int'(status), 0);

    measure(2'd0, 100, 32'd0, cnt);
    chk(near(cnt, 400), "R3 src0 100 ticks", cnt, 400);

    measure(2'd1, 150, 32'd0, cnt);
    chk(near(cnt, 100), "R4 src1 150 ticks", cnt, 100);
    repeat (50) @(negedge clk);
    chk(int'(status[24:0]) == cnt && status[25], "R8 count held while done", int'(status[24:0]), cnt);

    wr(32'd0);
    repeat (12) @(negedge clk);
    chk(status[25] == 1'b0, "R5 stop clears done", int'(status[25]), 0);

    measure(2'd0, 300, 32'd0, cnt);
    chk(cnt == CMAX, "R7 saturation", cnt, CMAX);

    measure(2'd0, 60, 32'hFFE0_0000, cnt);
    chk(near(cnt, 240), "R2 upper control bits ignored", cnt, 240);

    measure(2'd2, 50, 32'd0, prev);
    chk(near(prev, 200), "R3 src2 running", prev, 200);
    wr(32'd0);
    repeat (10) @(negedge clk);
    run2 = 0;
    measure(2'd2, 40, 32'd0, cs);
    chk(cs == prev, "R6 short run on stopped clock", cs, prev);
    measure(2'd2, 160, 32'd0, cl);
    chk(cl == cs, "R6 long run equals short run", cl, cs);

    wr(32'd0);
    repeat (10) @(negedge clk);
    run2 = 1;
    measure(2'd2, 30, 32'd0, cnt);
    chk(near(cnt, 120), "R9 fresh count after restart", cnt, 120);

    wr(32'd0);
    repeat (60) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule